// File: doc/BRIEF.md
# Dithered DAC Code Generator with Paired Frequency Counters

This core is the digital half of a frequency-lock loop closed in software. A host compares the rate of a controlled oscillator against a reference by reading two free-running counters: one advances on the reference clock and the other on the oscillator output. A single read request captures both counts on the same reference edge, so the host always gets a matched pair. The oscillator count crosses into the reference domain as a Gray code through a flop synchronizer, so a captured value is always a count the oscillator really held, never a mix of two.

The host steers the oscillator by writing an integer base code and a fraction. Every reference cycle the core adds the fraction to an accumulator. In cycles where that add carries out, it drives base+1 to the DAC; in all other cycles it drives the base code. The filtered DAC output therefore settles between two adjacent codes. Work is organised in frames of 2^FRAC_W cycles. A new base/fraction pair waits in a holding register and becomes active only at a frame boundary. This keeps the carry count exact within every frame.

Top module: `fll_dither_core`

## Requirements
- R1: While `rst_ref_n` is low at a reference edge, `dac_code`, `snap_ref_cnt` and `snap_osc_cnt` are driven to 0.
- R2: Every `dac_code` value equals the active base code B, or the saturated value of B+1.
- R3: Frames are 2^FRAC_W reference cycles long, and the first frame starts at the first edge after reset is released. At frame offset c with active fraction F, the output is B+1 when ((c*F) mod 2^FRAC_W) + F >= 2^FRAC_W, and B otherwise. The output appears on `dac_code` after that same edge.
- R4: When 0 < F <= 2^(FRAC_W-1), no two consecutive outputs within a frame are both B+1. When F > 2^(FRAC_W-1), no two consecutive outputs within a frame are both B.
- R5: Each frame holds exactly F cycles at B+1.
- R6: A write (`cfg_we` high at an edge) goes to a holding register. Holding values become active on the edge that ends the current frame (offset 2^FRAC_W-1), so a frame never mixes settings. A later write in the same frame replaces an earlier one.
- R7: The oscillator count reaches the reference domain through a Gray code and changes by at most one bit per oscillator cycle. Successive captured oscillator counts rise by the oscillator-to-reference frequency ratio times the elapsed reference cycles, within a few counts.
- R8: When `snap_req` is high at a reference edge, `snap_ref_cnt` takes the number of reference edges since reset release, counted before that edge. `snap_osc_cnt` takes the synchronized oscillator count at that same edge.
- R9: While `snap_req` is low, both snapshot outputs hold their values.
- R10: When B is the largest code (2^CODE_W-1), the output saturates and stays at B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock; drives the dither logic and the snapshot registers |
| rst_ref_n | input | 1 | Synchronous active-low reset, reference domain |
| clk_osc | input | 1 | Controlled-oscillator clock |
| rst_osc_n | input | 1 | Synchronous active-low reset, oscillator domain |
| cfg_we | input | 1 | Write strobe for base code and fraction |
| cfg_base | input | CODE_W | Integer base DAC code |
| cfg_frac | input | FRAC_W | Fraction F added to the accumulator each cycle |
| snap_req | input | 1 | Capture both counters on this edge |
| dac_code | output | CODE_W | Dithered DAC control code |
| snap_ref_cnt | output | CNT_W | Captured reference count |
| snap_osc_cnt | output | CNT_W | Captured oscillator count, same edge |

## Verification
The hardest case to reach from the ports is a write that lands partway through a frame, with the old setting still required for the rest of that frame. A second hard case is two writes in one frame, where only the last may take effect. The stimulus reaches both by issuing writes at random frame offsets and by placing back-to-back writes in a single frame. Each write is followed by a run to the end of the next frame. The bench models every output cycle by cycle with the carry formula, so any early or late activation is caught. Snapshot pairs are taken at random times while the two clocks run at an unrelated ratio, which exposes torn or non-monotone oscillator counts.

// File: rtl/fll_dither_pkg.sv
// Shared defaults and types for the dithered code generator.
// Assumes nothing beyond IEEE 1800-2017 packages.
package fll_dither_pkg;
    localparam int unsigned DEF_CODE_W      = 10;
    localparam int unsigned DEF_FRAC_W      = 8;
    localparam int unsigned DEF_CNT_W       = 16;
    localparam int unsigned DEF_SYNC_STAGES = 2;

    // Shape of the dither pattern for a given fraction
    typedef enum logic [1:0] {
        DITHER_FLAT      = 2'd0,   // fraction zero: base code only
        DITHER_SPARSE_HI = 2'd1,   // base+1 cycles are isolated
        DITHER_SPARSE_LO = 2'd2    // base cycles are isolated
    } dither_regime_e;
endpackage

// File: rtl/fll_osc_gray_counter.sv
// Free-running counter in the oscillator domain, published as a registered
// Gray code so that a downstream synchronizer sees one bit change per step.
// Assumes clk_osc is a clean clock; reset is synchronous to clk_osc.
module fll_osc_gray_counter #(
    parameter int unsigned CNT_W = fll_dither_pkg::DEF_CNT_W
) (
    input  logic             clk_osc,
    input  logic             rst_osc_n,
    output logic [CNT_W-1:0] gray_out
);
    logic [CNT_W-1:0] bin_q;
    logic [CNT_W-1:0] bin_nxt;

    assign bin_nxt = bin_q + 1'b1;

    // Count oscillator cycles and register the Gray image of the next count
    always_ff @(posedge clk_osc) begin
        if (!rst_osc_n) begin
            bin_q    <= '0;
            gray_out <= '0;
        end else begin
            bin_q    <= bin_nxt;
            gray_out <= bin_nxt ^ (bin_nxt >> 1);
        end
    end

    // R7: published code moves by at most one bit per oscillator cycle
    assert_gray_one_bit_R7: assert property (@(posedge clk_osc) disable iff (!rst_osc_n)
        $countones(gray_out ^ $past(gray_out)) <= 1)
        else $error("gray code changed more than one bit");
endmodule

// File: rtl/fll_gray_sync.sv
// Brings a Gray-coded count into the reference domain through a flop chain
// and converts it back to binary.
// Assumes the source advances fewer than four counts per reference cycle.
module fll_gray_sync #(
    parameter int unsigned CNT_W  = fll_dither_pkg::DEF_CNT_W,
    parameter int unsigned STAGES = fll_dither_pkg::DEF_SYNC_STAGES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] gray_in,
    output logic [CNT_W-1:0] bin_out
);
    logic [CNT_W-1:0] chain_q [STAGES];

    // Shift the Gray code through the synchronizer stages
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
        end else begin
            chain_q[0] <= gray_in;
            for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
        end
    end

    // Gray to binary: each bit is the parity of itself and all bits above
    for (genvar i = 0; i < CNT_W; i++) begin : g_g2b
        assign bin_out[i] = ^chain_q[STAGES-1][CNT_W-1:i];
    end

    // R7: synchronized count only moves forward, by a small step
    assert_sync_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        CNT_W'(bin_out - $past(bin_out)) < CNT_W'(4))
        else $error("synchronized count jumped");
endmodule

// File: rtl/fll_dither_gen.sv
// Fractional dither of a DAC code between base and base+1. An accumulator
// adds the active fraction each cycle; a carry selects base+1 (saturating).
// New settings are held until the frame of 2^FRAC_W cycles ends.
// Assumes cfg_* are synchronous to clk.
module fll_dither_gen #(
    parameter int unsigned CODE_W = fll_dither_pkg::DEF_CODE_W,
    parameter int unsigned FRAC_W = fll_dither_pkg::DEF_FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CODE_W-1:0] cfg_base,
    input  logic [FRAC_W-1:0] cfg_frac,
    output logic [CODE_W-1:0] dac_code
);
    import fll_dither_pkg::*;

    localparam logic [CODE_W-1:0] CODE_MAX   = {CODE_W{1'b1}};
    localparam logic [FRAC_W-1:0] FRAME_LAST = {FRAC_W{1'b1}};
    localparam logic [FRAC_W-1:0] HALF       = FRAC_W'(1) << (FRAC_W-1);

    logic [CODE_W-1:0] hold_base, act_base;
    logic [FRAC_W-1:0] hold_frac, act_frac;
    logic [FRAC_W-1:0] frame_pos;
    logic [FRAC_W-1:0] acc_q;
    logic [FRAC_W-1:0] acc_sum;
    logic              carry;
    logic              frame_end;
    logic [CODE_W-1:0] code_nxt;
    logic              hi_q;
    logic [FRAC_W-1:0] used_frac;
    logic [FRAC_W:0]   chk_hi_cnt;
    dither_regime_e    regime;

    assign {carry, acc_sum} = {1'b0, acc_q} + {1'b0, act_frac};
    assign frame_end        = (frame_pos == FRAME_LAST);
    assign code_nxt         = (carry && act_base != CODE_MAX) ? CODE_W'(act_base + 1'b1)
                                                              : act_base;

    // Capture host settings into the holding registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_base <= '0;
            hold_frac <= '0;
        end else if (cfg_we) begin
            hold_base <= cfg_base;
            hold_frac <= cfg_frac;
        end
    end

    // Track frame position and promote held settings at the frame end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_pos <= '0;
            act_base  <= '0;
            act_frac  <= '0;
        end else begin
            frame_pos <= frame_pos + 1'b1;
            if (frame_end) begin
                act_base <= hold_base;
                act_frac <= hold_frac;
            end
        end
    end

    // Advance the fractional accumulator, restarting it with each frame
    always_ff @(posedge clk) begin
        if (!rst_n)         acc_q <= '0;
        else if (frame_end) acc_q <= '0;
        else                acc_q <= acc_sum;
    end

    // Register the output code with the carry and fraction that produced it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dac_code  <= '0;
            hi_q      <= 1'b0;
            used_frac <= '0;
        end else begin
            dac_code  <= code_nxt;
            hi_q      <= carry;
            used_frac <= act_frac;
        end
    end

    // Checker only: count carries in the running frame
    always_ff @(posedge clk) begin
        if (!rst_n)              chk_hi_cnt <= '0;
        else if (frame_pos == 0) chk_hi_cnt <= {{FRAC_W{1'b0}}, carry};
        else                     chk_hi_cnt <= chk_hi_cnt + {{FRAC_W{1'b0}}, carry};
    end

    // Classify the fraction behind the latest output
    always_comb begin
        if (used_frac == '0)       regime = DITHER_FLAT;
        else if (used_frac <= HALF) regime = DITHER_SPARSE_HI;
        else                       regime = DITHER_SPARSE_LO;
    end

    // R2: output is the base code or its saturated successor
    assert_code_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_code == $past(act_base)) ||
        (dac_code == (($past(act_base) == CODE_MAX) ? CODE_MAX : CODE_W'($past(act_base) + 1'b1))))
        else $error("dac_code outside base pair");

    // R4: the minority level lasts a single cycle
    assert_sparse_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_pos != 1 && regime == DITHER_SPARSE_HI) |-> !(hi_q && $past(hi_q)))
        else $error("two adjacent high cycles");
    assert_sparse_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_pos != 1 && regime == DITHER_SPARSE_LO) |-> !(!hi_q && !$past(hi_q)))
        else $error("two adjacent low cycles");

    // R5: carries in a finished frame equal the fraction
    assert_frame_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_pos == 0) |-> (chk_hi_cnt == {1'b0, used_frac}))
        else $error("frame carry count differs from fraction");

    // R6: active settings change only at a frame boundary
    assert_update_at_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_pos != 0) |-> ($stable(act_base) && $stable(act_frac)))
        else $error("settings changed mid-frame");
endmodule

// File: rtl/fll_dither_core.sv
// Top: dithered DAC code generator plus a reference counter and a
// Gray-synchronized oscillator counter, both captured on one read edge.
// Assumes the oscillator runs below three times the reference rate.
module fll_dither_core #(
    parameter int unsigned CODE_W      = fll_dither_pkg::DEF_CODE_W,
    parameter int unsigned FRAC_W      = fll_dither_pkg::DEF_FRAC_W,
    parameter int unsigned CNT_W       = fll_dither_pkg::DEF_CNT_W,
    parameter int unsigned SYNC_STAGES = fll_dither_pkg::DEF_SYNC_STAGES
) (
    input  logic              clk_ref,
    input  logic              rst_ref_n,
    input  logic              clk_osc,
    input  logic              rst_osc_n,
    input  logic              cfg_we,
    input  logic [CODE_W-1:0] cfg_base,
    input  logic [FRAC_W-1:0] cfg_frac,
    input  logic              snap_req,
    output logic [CODE_W-1:0] dac_code,
    output logic [CNT_W-1:0]  snap_ref_cnt,
    output logic [CNT_W-1:0]  snap_osc_cnt
);
    logic [CNT_W-1:0] ref_cnt;
    logic [CNT_W-1:0] osc_gray;
    logic [CNT_W-1:0] osc_bin_ref;

    fll_dither_gen #(.CODE_W(CODE_W), .FRAC_W(FRAC_W)) u_dither (
        .clk      (clk_ref),
        .rst_n    (rst_ref_n),
        .cfg_we   (cfg_we),
        .cfg_base (cfg_base),
        .cfg_frac (cfg_frac),
        .dac_code (dac_code)
    );

    fll_osc_gray_counter #(.CNT_W(CNT_W)) u_osc_cnt (
        .clk_osc   (clk_osc),
        .rst_osc_n (rst_osc_n),
        .gray_out  (osc_gray)
    );

    fll_gray_sync #(.CNT_W(CNT_W), .STAGES(SYNC_STAGES)) u_osc_sync (
        .clk     (clk_ref),
        .rst_n   (rst_ref_n),
        .gray_in (osc_gray),
        .bin_out (osc_bin_ref)
    );

    // Count reference cycles since reset release
    always_ff @(posedge clk_ref) begin
        if (!rst_ref_n) ref_cnt <= '0;
        else            ref_cnt <= ref_cnt + 1'b1;
    end

    // Capture both counts together on a read request
    always_ff @(posedge clk_ref) begin
        if (!rst_ref_n) begin
            snap_ref_cnt <= '0;
            snap_osc_cnt <= '0;
        end else if (snap_req) begin
            snap_ref_cnt <= ref_cnt;
            snap_osc_cnt <= osc_bin_ref;
        end
    end

    // R9: snapshots hold while no read is requested
    assert_snap_hold_R9: assert property (@(posedge clk_ref) disable iff (!rst_ref_n)
        !$past(snap_req) |-> ($stable(snap_ref_cnt) && $stable(snap_osc_cnt)))
        else $error("snapshot moved without a request");
endmodule

// File: tb/fll_dither_core_bench.sv
`timescale 1ns/1ps
module fll_dither_core_bench;
    localparam int CODE_W = 10;
    localparam int FRAC_W = 8;
    localparam int CNT_W  = 16;
    localparam int FRAME  = 256;
    localparam int HALFF  = 128;
    localparam int CMAX   = 1023;

    logic clk_ref = 0, clk_osc = 0;
    logic rst_ref_n = 0, rst_osc_n = 0;
    logic cfg_we = 0, snap_req = 0;
    logic [CODE_W-1:0] cfg_base = '0;
    logic [FRAC_W-1:0] cfg_frac = '0;
    logic [CODE_W-1:0] dac_code;
    logic [CNT_W-1:0]  snap_ref_cnt, snap_osc_cnt;

    always #10 clk_ref = ~clk_ref;   // 50 MHz reference
    always #7  clk_osc = ~clk_osc;   // unrelated oscillator rate

    fll_dither_core u_fll_dither_core (
        .clk_ref(clk_ref), .rst_ref_n(rst_ref_n), .clk_osc(clk_osc), .rst_osc_n(rst_osc_n),
        .cfg_we(cfg_we), .cfg_base(cfg_base), .cfg_frac(cfg_frac), .snap_req(snap_req),
        .dac_code(dac_code), .snap_ref_cnt(snap_ref_cnt), .snap_osc_cnt(snap_osc_cnt)
    );

    int n_checks = 0, n_errs = 0;
    int edge_n = 0;
    int m_act_x = 0, m_act_f = 0, m_hold_x = 0, m_hold_f = 0;
    int frame_hi = 0, prev_hi = 0;
    int last_e = 0, last_osc = 0;
    bit have_snap = 0, done = 0;
    logic [CNT_W-1:0] held_ref = '0, held_osc = '0;

    function automatic int carry_at(int c, int f);
        return ((((c * f) % FRAME) + f) >= FRAME) ? 1 : 0;
    endfunction

    function automatic int code_for(int x, int hi);
        if (hi != 0 && x != CMAX) return x + 1;
        return x;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s actual=%0d expected=%0d (edge %0d)", req, act, exp, edge_n);
        end
    endtask

    // One reference cycle: inputs already set, check after the edge
    task automatic step();
        int e, c, hi, obs, d_osc, d_exp;
        @(posedge clk_ref);
        @(negedge clk_ref);
        e = edge_n; edge_n++;
        c = e % FRAME;
        hi = carry_at(c, m_act_f);
        check(int'(dac_code) == code_for(m_act_x, hi), "R3 R6 dac_code", int'(dac_code), code_for(m_act_x, hi));
        if (m_act_x == CMAX)
            check(int'(dac_code) == CMAX, "R10 saturated code", int'(dac_code), CMAX);
        else
            check(int'(dac_code) == m_act_x || int'(dac_code) == m_act_x + 1, "R2 code pair", int'(dac_code), m_act_x);
        obs = (int'(dac_code) != m_act_x) ? 1 : 0;
        if (m_act_x != CMAX) begin
            if (c > 0 && m_act_f != 0 && m_act_f <= HALFF)
                check(!(obs == 1 && prev_hi == 1), "R4 isolated high", obs, 0);
            if (c > 0 && m_act_f > HALFF)
                check(!(obs == 0 && prev_hi == 0), "R4 isolated low", obs, 1);
            frame_hi = (c == 0) ? obs : frame_hi + obs;
            if (c == FRAME - 1)
                check(frame_hi == m_act_f, "R5 frame high count", frame_hi, m_act_f);
        end
        prev_hi = obs;
        if (snap_req) begin
            check(int'(snap_ref_cnt) == (e % 65536), "R8 reference snapshot", int'(snap_ref_cnt), e % 65536);
            if (have_snap) begin
                d_osc = (int'(snap_osc_cnt) - last_osc + 65536) % 65536;
                d_exp = ((e - last_e) * 10) / 7;
                check(d_osc >= d_exp - 3 && d_osc <= d_exp + 3, "R7 oscillator delta", d_osc, d_exp);
            end else begin
                d_exp = (e * 10) / 7;
                check(int'(snap_osc_cnt) <= d_exp + 3 && int'(snap_osc_cnt) + 8 >= d_exp,
                      "R8 first oscillator snapshot", int'(snap_osc_cnt), d_exp);
            end
            have_snap = 1; last_e = e; last_osc = int'(snap_osc_cnt);
            held_ref = snap_ref_cnt; held_osc = snap_osc_cnt;
        end else begin
            check(snap_ref_cnt == held_ref && snap_osc_cnt == held_osc, "R9 snapshot hold",
                  int'(snap_ref_cnt), int'(held_ref));
        end
        if (c == FRAME - 1) begin m_act_x = m_hold_x; m_act_f = m_hold_f; end
        if (cfg_we) begin m_hold_x = int'(cfg_base); m_hold_f = int'(cfg_frac); end
    endtask

    task automatic step_rand();
        snap_req = ($urandom % 16) == 0;
        step();
        snap_req = 0;
    endtask

    // Write a setting, then run through the end of the frame that uses it
    task automatic apply(int x, int f);
        int w, k;
        cfg_base = CODE_W'(x); cfg_frac = FRAC_W'(f); cfg_we = 1;
        step();
        cfg_we = 0;
        w = edge_n - 1;
        k = (w + 1) / FRAME + 1;
        while (edge_n < FRAME * (k + 1)) step_rand();
    endtask

    initial begin
        int unsigned seed_init;
        seed_init = $urandom(32'h1F0C_5EED);
        repeat (4) @(posedge clk_ref);
        @(negedge clk_ref);
        // R1: reset values
        check(dac_code == '0, "R1 reset dac_code", int'(dac_code), 0);
        check(snap_ref_cnt == '0, "R1 reset ref snapshot", int'(snap_ref_cnt), 0);
        check(snap_osc_cnt == '0, "R1 reset osc snapshot", int'(snap_osc_cnt), 0);
        rst_ref_n = 1; rst_osc_n = 1;
        repeat (30) step_rand();
        snap_req = 1; step(); snap_req = 0;
        // Directed corners
        apply(100, 1);
        apply(200, 128);
        apply(300, 255);
        apply(5, 0);
        apply(CMAX, 77);       // R10 saturation
        apply(512, 129);
        // R6: two writes in one frame, only the last counts
        cfg_base = 10'd40; cfg_frac = 8'd3; cfg_we = 1; step();
        cfg_base = 10'd41; cfg_frac = 8'd250; step();
        cfg_we = 0;
        repeat (2 * FRAME) step_rand();
        // Random settings at random frame offsets
        for (int i = 0; i < 8; i++) begin
            repeat ($urandom % 200) step_rand();
            apply(int'($urandom % 1024), int'($urandom % 256));
        end
        snap_req = 1; step(); snap_req = 0;
        step();
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_errs++; n_checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end
endmodule